// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer Unit

The block gathers up to three down-counting timer channels behind one small register window. A shared area at the bottom of the window holds a run register and an optional single-bit output-control register. Above that, each channel has a bank of its own. Every channel divides the clock by a selectable power of four and decrements its count on each prescaled tick. When a tick finds the count at zero, the channel reloads the count from its reload register and raises an underflow flag. The flag drives that channel's own interrupt line when the channel's interrupt enable is set.

Channel 2 is a build-time option and is the only channel that has a capture register. It also has a capture strobe that copies its live count. Any access the window does not accept returns zero and leaves all state as it was. Such an access also raises a one-cycle error pulse on the cycle after the access.

Top module: `tmu_top`

## Requirements
- R1: After reset, each channel's reload and count registers read 0xFFFFFFFF, every control register reads 0, the run register reads 0, the output-control register reads 0, and all interrupt lines are low.
- R2: Byte offset 0x04 is the run register. Write bits 0, 1 and 2 run (1) or stop (0) channels 0, 1 and 2. Reading it returns the last accepted write's bits 2:0, with all higher bits reading 0.
- R3: Channel banks start at offsets 0x08 (channel 0), 0x14 (channel 1) and 0x20 (channel 2). Decode picks the highest base that the offset reaches. Within a bank, local offset 0x0 is the reload register, 0x4 the count and 0x8 the control register. Each register reads back what was written to it.
- R4: A running channel whose control bits 2:0 hold p (0 to 4) ticks once every 4^(p+1) clocks. A tick decrements a non-zero count. A tick on a zero count loads the reload value and sets the underflow flag (control bit 8). The first tick comes 4^(p+1) clocks after the run bit takes effect, or after the last control write.
- R5: A channel's interrupt line is high exactly when its underflow flag and its interrupt enable (control bit 5) are both set.
- R6: A control write with bit 8 clear clears the underflow flag. A control write with bit 8 set leaves the flag unchanged. Every control write restarts the prescaler.
- R7: Clearing a channel's run bit freezes its count, flag and prescaler phase. Setting the bit again resumes counting from the frozen count and phase.
- R8: When the output-control option is built, offset 0x00 keeps only bit 0 of a write. The output `outSel` shows that bit, and reads return it with the other bits zero.
- R9: When channel 2 is built, its local offset 0xC (bus offset 0x2C) is a capture register. The capture register can be written and read back. A high `capStrobe` copies channel 2's current count into it.
- R10: The following accesses are invalid: a misaligned offset, any offset above 0x2C, offset 0x00 without the output-control option, any offset from 0x20 up without channel 2, and a run write with bit 2 set without channel 2. An invalid read returns 0. An invalid write changes nothing. Each invalid access drives `busErr` high for exactly the cycle after it.
- R11: A control write whose bits 2:0 exceed 4 is invalid under R10 and leaves that control register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busRead | input | 1 | Read request this cycle |
| busWrite | input | 1 | Write request this cycle |
| busAddr | input | ADDR_W | Byte offset within the window |
| busWdata | input | CNT_W | Write data |
| busRdata | output | CNT_W | Read data, same cycle as busRead |
| busErr | output | 1 | One-cycle pulse after an invalid access |
| capStrobe | input | 1 | Copies channel 2 count into its capture register |
| outSel | output | 1 | Output-control bit |
| irq | output | 3 | Per-channel interrupt lines |

## Verification
The bench first targets the prescaler timing. It places the interrupt edge for random prescale settings and counts, and for the slowest setting. A design that miscounts the prescaled period by even one clock raises the interrupt a cycle early or late. The bench stops a channel in mid-period and restarts it. A design that reset the prescaler phase on restart, or let the count drift while stopped, shows a late or wrong count at the sampled cycle.

The bench also probes the decode edges. These include offsets that fall between banks, misaligned writes that would alias a real register, reserved prescale codes, and a second build that has neither channel 2 nor the output-control register. A decoder that compared ranges in the wrong order, or that accepted the write, would corrupt the aliased register or return nonzero data. It would also fail to pulse the error line. Flag handling is probed as well: a design that cleared the flag on every control write would drop the interrupt when bit 8 is written as one.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
  // Strobes from the decode/control side to one channel datapath
  typedef struct packed {
    logic wrReload;
    logic wrCount;
    logic wrCtrl;
    logic wrCap;
    logic run;
  } chanCmd_t;

  localparam int PRE_SEL_MAX = 4;
  localparam int PRE_W       = 2 * (PRE_SEL_MAX + 1);
  localparam int IE_BIT      = 5;
  localparam int FLAG_BIT    = 8;
  localparam int NUM_SLOTS   = 3;
endpackage

// File: rtl/tmu_chan.sv
module tmu_chan
  import tmu_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter bit HAS_CAP = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanCmd_t         cmd,
  input  logic [CNT_W-1:0] wdata,
  input  logic             capStrobe,
  output logic [CNT_W-1:0] reloadQ,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] ctrlQ,
  output logic [CNT_W-1:0] capQ,
  output logic             irq
);
  logic [2:0]       preSel;
  logic             ieQ;
  logic             flagQ;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] divLast;
  logic             tick;
  logic             atZero;

  always_comb begin
    divLast = '0;
    for (int k = 0; k <= PRE_SEL_MAX; k++) begin
      if (preSel == 3'(k)) divLast = PRE_W'((1 << (2 * (k + 1))) - 1);
    end
  end

  assign tick   = cmd.run && !cmd.wrCtrl && (preCnt == divLast);
  assign atZero = (countQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      countQ  <= '1;
      reloadQ <= '1;
      preSel  <= '0;
      ieQ     <= 1'b0;
      flagQ   <= 1'b0;
    end else begin
      if (cmd.wrCtrl)   preCnt <= '0;
      else if (tick)    preCnt <= '0;
      else if (cmd.run) preCnt <= preCnt + 1'b1;

      if (cmd.wrReload) reloadQ <= wdata;

      if (cmd.wrCount)  countQ <= wdata;
      else if (tick)    countQ <= atZero ? reloadQ : countQ - 1'b1;

      if (cmd.wrCtrl) begin
        preSel <= wdata[2:0];
        ieQ    <= wdata[IE_BIT];
        flagQ  <= flagQ & wdata[FLAG_BIT];
      end else if (tick && atZero) begin
        flagQ  <= 1'b1;
      end
    end
  end

  generate
    if (HAS_CAP) begin : g_cap
      always_ff @(posedge clk) begin
        if (!rstN)          capQ <= '0;
        else if (cmd.wrCap) capQ <= wdata;
        else if (capStrobe) capQ <= countQ;
      end
    end else begin : g_nocap
      logic unusedCapIn;
      assign unusedCapIn = capStrobe ^ cmd.wrCap;
      assign capQ = '0;
    end
  endgenerate

  always_comb begin
    ctrlQ           = '0;
    ctrlQ[2:0]      = preSel;
    ctrlQ[IE_BIT]   = ieQ;
    ctrlQ[FLAG_BIT] = flagQ;
  end

  assign irq = flagQ & ieQ;

  // R7
  hold_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.run && !cmd.wrCount) |=> $stable(countQ));

  // R4
  underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> ($past(countQ) == '0 && $past(cmd.run)));

  // R4
  pre_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= divLast);
endmodule

// File: rtl/tmu_ctrl.sv
module tmu_ctrl
  import tmu_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter bit HAS_CH2    = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            busRead,
  input  logic                            busWrite,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [2:0]                      wLow,
  output logic [DATA_W-1:0]               busRdata,
  output logic                            busErr,
  output logic                            outSel,
  output chanCmd_t [NUM_SLOTS-1:0]        cmd,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] rdReload,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] rdCount,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] rdCtrl,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] rdCap
);
  localparam logic [ADDR_W-1:0] BASE0  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] BASE1  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] BASE2  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] RUNOFS = ADDR_W'('h04);

  logic [2:0] startQ;
  logic       outQ;
  logic       errQ;
  logic       access, aligned, isStart, isOut, chHit;
  logic [1:0] chIdx;
  logic [3:0] lcl;
  logic [1:0] regIdx;
  logic       startBad, ctrlBad, valid, wrOk;

  assign access  = busRead | busWrite;
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    isStart = 1'b0;
    isOut   = 1'b0;
    chHit   = 1'b0;
    chIdx   = 2'd0;
    lcl     = '0;
    if (busAddr >= BASE2) begin
      chIdx = 2'd2;
      lcl   = 4'(busAddr - BASE2);
      chHit = HAS_CH2 && ((busAddr - BASE2) <= ADDR_W'('hC));
    end else if (busAddr >= BASE1) begin
      chIdx = 2'd1;
      lcl   = 4'(busAddr - BASE1);
      chHit = (lcl <= 4'h8);
    end else if (busAddr >= BASE0) begin
      chIdx = 2'd0;
      lcl   = 4'(busAddr - BASE0);
      chHit = (lcl <= 4'h8);
    end else if (busAddr == RUNOFS) begin
      isStart = 1'b1;
    end else if (busAddr == '0) begin
      isOut = HAS_OUTCTL;
    end
  end

  assign regIdx   = lcl[3:2];
  assign startBad = isStart && busWrite && !HAS_CH2 && wLow[2];
  assign ctrlBad  = chHit && (regIdx == 2'd2) && busWrite && (wLow > 3'(PRE_SEL_MAX));
  assign valid    = aligned && (isStart || isOut || chHit) && !startBad && !ctrlBad;
  assign wrOk     = busWrite && valid;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      cmd[i].wrReload = wrOk && chHit && (chIdx == 2'(i)) && (regIdx == 2'd0);
      cmd[i].wrCount  = wrOk && chHit && (chIdx == 2'(i)) && (regIdx == 2'd1);
      cmd[i].wrCtrl   = wrOk && chHit && (chIdx == 2'(i)) && (regIdx == 2'd2);
      cmd[i].wrCap    = wrOk && chHit && (chIdx == 2'(i)) && (regIdx == 2'd3);
      cmd[i].run      = startQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      outQ   <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      if (wrOk && isStart) startQ <= wLow;
      if (wrOk && isOut)   outQ   <= wLow[0];
      errQ <= access && !valid;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busRead && valid) begin
      if (isStart)    busRdata = DATA_W'(startQ);
      else if (isOut) busRdata = DATA_W'(outQ);
      else begin
        case (regIdx)
          2'd0:    busRdata = rdReload[chIdx];
          2'd1:    busRdata = rdCount[chIdx];
          2'd2:    busRdata = rdCtrl[chIdx];
          default: busRdata = rdCap[chIdx];
        endcase
      end
    end
  end

  assign busErr = errQ;
  assign outSel = outQ;

  // R10
  err_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busRead || busWrite));

  // R2
  start_lite_chk: assert property (@(posedge clk) disable iff (!rstN)
    startQ[2] |-> HAS_CH2);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrite && busAddr == '0) |=> $stable(outQ));

  // R2
  start_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWrite |=> $stable(startQ));
endmodule

// File: rtl/tmu_top.sv
module tmu_top
  import tmu_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int CNT_W      = 32,
  parameter bit HAS_CH2    = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic              busErr,
  input  logic              capStrobe,
  output logic              outSel,
  output logic [2:0]        irq
);
  chanCmd_t [NUM_SLOTS-1:0]              cmd;
  logic [NUM_SLOTS-1:0][CNT_W-1:0]       rdReload, rdCount, rdCtrl, rdCap;

  tmu_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(CNT_W), .HAS_CH2(HAS_CH2), .HAS_OUTCTL(HAS_OUTCTL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busRead(busRead), .busWrite(busWrite),
    .busAddr(busAddr), .wLow(busWdata[2:0]), .busRdata(busRdata),
    .busErr(busErr), .outSel(outSel), .cmd(cmd),
    .rdReload(rdReload), .rdCount(rdCount), .rdCtrl(rdCtrl), .rdCap(rdCap)
  );

  generate
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_ch
      if (i < 2 || HAS_CH2) begin : g_on
        tmu_chan #(.CNT_W(CNT_W), .HAS_CAP(i == 2 ? 1'b1 : 1'b0)) u_chan (
          .clk(clk), .rstN(rstN), .cmd(cmd[i]), .wdata(busWdata),
          .capStrobe(i == 2 ? capStrobe : 1'b0),
          .reloadQ(rdReload[i]), .countQ(rdCount[i]), .ctrlQ(rdCtrl[i]),
          .capQ(rdCap[i]), .irq(irq[i])
        );
      end else begin : g_off
        assign rdReload[i] = '0;
        assign rdCount[i]  = '0;
        assign rdCtrl[i]   = '0;
        assign rdCap[i]    = '0;
        assign irq[i]      = 1'b0;
      end
    end
  endgenerate
endmodule

// File: tb/tmu_top_test.sv
module tmu_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rd = 1'b0, wr = 1'b0, cap = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, liteRdata;
  logic        err, liteErr, outSel, liteOut;
  logic [2:0]  irq, liteIrq;

  int total = 0, bad = 0;
  logic [31:0] gotData, gotLite;
  logic        gotErr, gotLiteErr;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  tmu_top uut (
    .clk(clk), .rstN(rstN), .busRead(rd), .busWrite(wr), .busAddr(addr),
    .busWdata(wdata), .busRdata(rdata), .busErr(err), .capStrobe(cap),
    .outSel(outSel), .irq(irq)
  );

  tmu_top #(.HAS_CH2(1'b0), .HAS_OUTCTL(1'b0)) uutLite (
    .clk(clk), .rstN(rstN), .busRead(rd), .busWrite(wr), .busAddr(addr),
    .busWdata(wdata), .busRdata(liteRdata), .busErr(liteErr), .capStrobe(cap),
    .outSel(liteOut), .irq(liteIrq)
  );

  function automatic logic [5:0] baseOf(int ch);
    return (ch == 0) ? 6'h08 : (ch == 1) ? 6'h14 : 6'h20;
  endfunction

  function automatic int divOf(int p);
    return 1 << (2 * (p + 1));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busOp(logic doWr, logic [5:0] ad, logic [31:0] d);
    rd = !doWr; wr = doWr; addr = ad; wdata = d;
    #2;
    gotData = rdata; gotLite = liteRdata;
    @(negedge clk);
    gotErr = err; gotLiteErr = liteErr;
    rd = 1'b0; wr = 1'b0;
  endtask

  task automatic waitN(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    waitN(3);
    rstN = 1'b1;
    waitN(1);

    // R1 reset state
    check("R1 irq", {29'd0, irq}, 32'd0);
    check("R1 outSel", {31'd0, outSel}, 32'd0);
    busOp(0, 6'h08, 0); check("R1 reload0", gotData, 32'hFFFFFFFF);
    busOp(0, 6'h18, 0); check("R1 count1", gotData, 32'hFFFFFFFF);
    busOp(0, 6'h28, 0); check("R1 ctrl2", gotData, 32'd0);
    busOp(0, 6'h04, 0); check("R1 run", gotData, 32'd0);
    check("R10 valid access no err", {31'd0, gotErr}, 32'd0);

    // R3 random register traffic on stopped channels
    for (int it = 0; it < 24; it++) begin
      int ch = $urandom % 3;
      int rg = $urandom % 2;
      logic [31:0] d = $urandom;
      busOp(1, baseOf(ch) + 6'(rg * 4), d);
      busOp(0, baseOf(ch) + 6'(rg * 4), 0);
      check("R3 readback", gotData, d);
    end

    // R2 run register
    busOp(1, 6'h04, 32'h5);
    busOp(0, 6'h04, 0); check("R2 run read", gotData, 32'h5);
    busOp(1, 6'h04, 32'hFFFFFFFA);
    busOp(0, 6'h04, 0); check("R2 run upper bits", gotData, 32'h2);
    busOp(1, 6'h04, 0);

    // R4 R5 random prescale and count
    for (int it = 0; it < 8; it++) begin
      int ch = $urandom % 3;
      int p = $urandom % 3;
      int n = $urandom % 6;
      logic [31:0] rl = 32'($urandom % 1000) + 32'd10;
      busOp(1, baseOf(ch), rl);
      busOp(1, baseOf(ch) + 6'h4, 32'(n));
      busOp(1, baseOf(ch) + 6'h8, 32'(p) | 32'h20);
      busOp(1, 6'h04, 32'(1 << ch));
      waitN((n + 1) * divOf(p) - 1);
      check("R4 no early irq", {31'd0, irq[ch]}, 32'd0);
      waitN(1);
      check("R5 irq at underflow", {31'd0, irq[ch]}, 32'd1);
      busOp(1, 6'h04, 0);
      busOp(0, baseOf(ch) + 6'h4, 0); check("R4 reload on underflow", gotData, rl);
      busOp(0, baseOf(ch) + 6'h8, 0); check("R4 flag bit", gotData, 32'(p) | 32'h120);
      busOp(1, baseOf(ch) + 6'h8, 32'(p) | 32'h100);
      check("R5 irq masked", {31'd0, irq[ch]}, 32'd0);
      busOp(0, baseOf(ch) + 6'h8, 0); check("R6 flag kept", gotData, 32'(p) | 32'h100);
      busOp(1, baseOf(ch) + 6'h8, 32'(p) | 32'h120);
      check("R5 irq unmasked", {31'd0, irq[ch]}, 32'd1);
      busOp(1, baseOf(ch) + 6'h8, 32'(p) | 32'h20);
      check("R6 flag cleared", {31'd0, irq[ch]}, 32'd0);
    end

    // R4 slowest prescale
    busOp(1, 6'h0C, 32'd0);
    busOp(1, 6'h10, 32'h24);
    busOp(1, 6'h04, 32'h1);
    waitN(1023);
    check("R4 slow no early irq", {31'd0, irq[0]}, 32'd0);
    waitN(1);
    check("R4 slow irq", {31'd0, irq[0]}, 32'd1);
    busOp(1, 6'h04, 0);

    // R7 freeze and resume
    busOp(1, 6'h14, 32'd100);
    busOp(1, 6'h18, 32'd40);
    busOp(1, 6'h1C, 32'h20);
    busOp(1, 6'h04, 32'h2);
    waitN(20);
    busOp(1, 6'h04, 0);
    busOp(0, 6'h18, 0); check("R7 count at stop", gotData, 32'd35);
    waitN(60);
    busOp(0, 6'h18, 0); check("R7 count frozen", gotData, 32'd35);
    check("R7 irq frozen", {31'd0, irq[1]}, 32'd0);
    busOp(1, 6'h04, 32'h2);
    waitN(2);
    busOp(0, 6'h18, 0); check("R7 phase kept", gotData, 32'd35);
    busOp(0, 6'h18, 0); check("R7 resumed", gotData, 32'd34);
    busOp(1, 6'h04, 0);

    // R8 output control
    busOp(1, 6'h00, 32'hFFFFFFFF);
    check("R8 outSel set", {31'd0, outSel}, 32'd1);
    busOp(0, 6'h00, 0); check("R8 read", gotData, 32'd1);
    busOp(1, 6'h00, 32'hFFFFFFFE);
    check("R8 outSel clear", {31'd0, outSel}, 32'd0);

    // R9 capture
    busOp(1, 6'h24, 32'h1234);
    cap = 1'b1; waitN(1); cap = 1'b0;
    busOp(0, 6'h2C, 0); check("R9 capture strobe", gotData, 32'h1234);
    busOp(1, 6'h2C, 32'hA5A5);
    busOp(0, 6'h2C, 0); check("R9 capture write", gotData, 32'hA5A5);

    // R10 invalid accesses
    busOp(1, 6'h0C, 32'd7);
    busOp(1, 6'h0D, 32'd99); check("R10 misaligned err", {31'd0, gotErr}, 32'd1);
    waitN(1); check("R10 err one cycle", {31'd0, err}, 32'd0);
    busOp(0, 6'h0C, 0); check("R10 misaligned ignored", gotData, 32'd7);
    busOp(0, 6'h30, 0); check("R10 high read zero", gotData, 32'd0);
    check("R10 high read err", {31'd0, gotErr}, 32'd1);
    busOp(0, 6'h3C, 0); check("R10 top read err", {31'd0, gotErr}, 32'd1);

    // R11 reserved prescale
    busOp(1, 6'h10, 32'h21);
    busOp(1, 6'h10, 32'h7); check("R11 reserved err", {31'd0, gotErr}, 32'd1);
    busOp(0, 6'h10, 0); check("R11 ctrl unchanged", gotData, 32'h21);

    // R10 build without channel 2 or output control
    busOp(0, 6'h24, 0);
    check("R10 lite ch2 read zero", gotLite, 32'd0);
    check("R10 lite ch2 err", {31'd0, gotLiteErr}, 32'd1);
    check("R10 full ch2 ok", {31'd0, gotErr}, 32'd0);
    busOp(0, 6'h00, 0);
    check("R10 lite outctl err", {31'd0, gotLiteErr}, 32'd1);
    busOp(1, 6'h04, 32'h4);
    check("R10 lite run bit2 err", {31'd0, gotLiteErr}, 32'd1);
    busOp(1, 6'h04, 0);
    busOp(1, 6'h04, 32'h6);
    busOp(0, 6'h04, 0);
    check("R10 lite run ignored", gotLite, 32'd0);
    busOp(1, 6'h04, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule